// File: doc/BRIEF.md
# Register Status Rename Table

This block is the architectural register file of a tag-based out-of-order scheduler. Each register carries a value and a producer tag. Tag zero means "no producer pending". Instructions issue in program order. For each of the issuing instruction's sources, the table answers in the same cycle. The answer is either a ready value, or the tag of the station the consumer must wait for.

At the clock edge that ends the issue cycle, the destination register's tag is overwritten with the tag of the issuing station. Results return on a shared bus that carries a data word and the tag of the station that produced it. A register captures a broadcast only while its tag still names that station. A result from a producer that has since been superseded is therefore dropped, and write-after-write and write-after-read ordering is kept without any stall.

A flush empties every tag and keeps the values, so the table returns to a fully ready state after a pipeline squash.

Top module: `rrt_rename_table`

## Requirements
- R1: After reset, every register has an empty tag and a zero value, so every lookup returns ready with value 0.
- R2: A lookup of a register whose tag is 0 returns `src_ready_o`=1, the stored value on `src_value_o` and 0 on `src_tag_o`.
- R3: A lookup of a register with a nonzero tag that is not being broadcast in that cycle returns `src_ready_o`=0 and that tag on `src_tag_o`.
- R4: A rename with a nonzero tag takes effect at the next clock edge. A lookup in the same cycle as the rename still sees the register's earlier state.
- R5: A valid broadcast whose nonzero tag equals a register's tag writes the bus data into that register's value and clears its tag at the next edge.
- R6: A broadcast whose tag differs from a register's tag leaves that register unchanged, and a broadcast with tag 0 changes no register.
- R7: When a rename and a matching broadcast hit the same register in one cycle, the register's tag becomes the new rename tag and its value still captures the bus data.
- R8: A lookup of a register whose tag matches a valid broadcast in the same cycle returns `src_ready_o`=1 with the bus data (bypass).
- R9: A flush clears every tag at the next edge and keeps every value. A rename in the flush cycle is discarded, while a matching broadcast in that cycle still writes its data.
- R10: The two lookup ports are independent and may name the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Clear all producer tags, keep values |
| src_addr_i | input | NUM_SRC x ADDR_W | Source register numbers, one per lookup port |
| src_ready_o | output | NUM_SRC | Source value is available |
| src_value_o | output | NUM_SRC x DATA_W | Source value, meaningful when ready |
| src_tag_o | output | NUM_SRC x TAG_W | Producer tag to wait on, 0 when ready |
| ren_valid_i | input | 1 | Rename the destination this cycle |
| ren_addr_i | input | ADDR_W | Destination register number |
| ren_tag_i | input | TAG_W | Issuing station tag, nonzero |
| res_valid_i | input | 1 | Result bus carries a result |
| res_tag_i | input | TAG_W | Tag of the producing station |
| res_data_i | input | DATA_W | Result data word |

## Verification
Two pairs of functions can coincide in one cycle. A rename can land in the same cycle as a broadcast that matches the same register. A lookup can land in the same cycle as a broadcast that resolves the register being read. Directed sequences build these collisions on purpose. The random phase draws bus tags mostly from tags that are currently pending, so both collisions recur many times.

The outcome is judged through the ports against a bench model. The new tag must survive the collision. The value captured during the collision is made visible by a later flush followed by a lookup. A bypassed lookup must return the bus word in its own cycle.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
   localparam int unsigned RRT_DEF_REGS   = 16;
   localparam int unsigned RRT_DEF_DATA_W = 32;
   localparam int unsigned RRT_DEF_TAG_W  = 4;
   localparam int unsigned RRT_DEF_SRC    = 2;

   // Per-port lookup outcome class
   typedef enum logic [1:0] {
      LK_STORED = 2'd0,
      LK_BYPASS = 2'd1,
      LK_WAIT   = 2'd2
   } lookup_kind_e;
endpackage

// File: rtl/rrt_ren_decode.sv
module rrt_ren_decode #(
   parameter int unsigned NUM_REGS = rrt_pkg::RRT_DEF_REGS,
   parameter int unsigned TAG_W    = rrt_pkg::RRT_DEF_TAG_W,
   localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ren_valid_i,
   input  logic [ADDR_W-1:0]   ren_addr_i,
   input  logic [TAG_W-1:0]    ren_tag_i,
   output logic [NUM_REGS-1:0] ren_hit_o
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
      assign ren_hit_o[g] = ren_valid_i && (ren_addr_i == ADDR_W'(g));
   end

   // R4: a rename must carry a real producer tag
   p_rename_tag_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ren_valid_i |-> (ren_tag_i != '0));

   // R4: at most one register is renamed per cycle
   p_one_rename_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ren_hit_o));
endmodule

// File: rtl/rrt_entry.sv
module rrt_entry #(
   parameter int unsigned DATA_W    = rrt_pkg::RRT_DEF_DATA_W,
   parameter int unsigned TAG_W     = rrt_pkg::RRT_DEF_TAG_W,
   parameter bit          CLEAR_VAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              ren_hit_i,
   input  logic [TAG_W-1:0]  ren_tag_i,
   input  logic              res_valid_i,
   input  logic [TAG_W-1:0]  res_tag_i,
   input  logic [DATA_W-1:0] res_data_i,
   output logic [TAG_W-1:0]  q_o,
   output logic [DATA_W-1:0] v_o
);
   logic [TAG_W-1:0]  q_r;
   logic [DATA_W-1:0] v_r;
   logic              bus_match;

   assign bus_match = res_valid_i && (res_tag_i != '0) && (q_r == res_tag_i);

   // Producer tag: flush beats rename, rename beats capture
   always_ff @(posedge clk) begin
      if (!rst_n)          q_r <= '0;
      else if (flush_i)    q_r <= '0;
      else if (ren_hit_i)  q_r <= ren_tag_i;
      else if (bus_match)  q_r <= '0;
   end

   // Value: variant chosen by parameter
   if (CLEAR_VAL) begin : g_val_rst
      always_ff @(posedge clk) begin
         if (!rst_n)         v_r <= '0;
         else if (bus_match) v_r <= res_data_i;
      end
   end else begin : g_val_norst
      always_ff @(posedge clk) begin
         if (bus_match) v_r <= res_data_i;
      end
   end

   assign q_o = q_r;
   assign v_o = v_r;

   p_rename_sets_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_hit_i && !flush_i) |=> (q_r == $past(ren_tag_i)));

   p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_match && !ren_hit_i && !flush_i) |=> (q_r == '0 && v_r == $past(res_data_i)));

   p_stale_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_match && !ren_hit_i && !flush_i) |=> ($stable(q_r) && $stable(v_r)));

   p_collision_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_match && ren_hit_i) |=> (v_r == $past(res_data_i)));

   p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (q_r == '0));
endmodule

// File: rtl/rrt_read_port.sv
module rrt_read_port #(
   parameter int unsigned NUM_REGS = rrt_pkg::RRT_DEF_REGS,
   parameter int unsigned DATA_W   = rrt_pkg::RRT_DEF_DATA_W,
   parameter int unsigned TAG_W    = rrt_pkg::RRT_DEF_TAG_W,
   localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ADDR_W-1:0]              addr_i,
   input  logic [NUM_REGS-1:0][TAG_W-1:0] q_all_i,
   input  logic [NUM_REGS-1:0][DATA_W-1:0] v_all_i,
   input  logic                           res_valid_i,
   input  logic [TAG_W-1:0]               res_tag_i,
   input  logic [DATA_W-1:0]              res_data_i,
   output logic                           ready_o,
   output logic [DATA_W-1:0]              value_o,
   output logic [TAG_W-1:0]               tag_o
);
   import rrt_pkg::*;

   logic [TAG_W-1:0]  sel_q;
   logic [DATA_W-1:0] sel_v;
   lookup_kind_e      kind;

   assign sel_q = q_all_i[addr_i];
   assign sel_v = v_all_i[addr_i];

   always_comb begin
      if (sel_q == '0)
         kind = LK_STORED;
      else if (res_valid_i && res_tag_i == sel_q)
         kind = LK_BYPASS;
      else
         kind = LK_WAIT;
   end

   always_comb begin
      unique case (kind)
         LK_STORED: begin ready_o = 1'b1; value_o = sel_v;      tag_o = '0;    end
         LK_BYPASS: begin ready_o = 1'b1; value_o = res_data_i; tag_o = '0;    end
         default:   begin ready_o = 1'b0; value_o = sel_v;      tag_o = sel_q; end
      endcase
   end

   // R3: a waiting answer always names a real producer
   p_wait_has_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_o |-> (tag_o != '0));

   // R8: a live broadcast for the selected producer is always forwarded
   p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_i && sel_q != '0 && res_tag_i == sel_q) |-> (ready_o && value_o == res_data_i));
endmodule

// File: rtl/rrt_rename_table.sv
module rrt_rename_table #(
   parameter int unsigned NUM_REGS  = rrt_pkg::RRT_DEF_REGS,
   parameter int unsigned DATA_W    = rrt_pkg::RRT_DEF_DATA_W,
   parameter int unsigned TAG_W     = rrt_pkg::RRT_DEF_TAG_W,
   parameter int unsigned NUM_SRC   = rrt_pkg::RRT_DEF_SRC,
   parameter bit          CLEAR_VAL = 1'b1,
   localparam int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           flush_i,
   input  logic [NUM_SRC-1:0][ADDR_W-1:0] src_addr_i,
   output logic [NUM_SRC-1:0]             src_ready_o,
   output logic [NUM_SRC-1:0][DATA_W-1:0] src_value_o,
   output logic [NUM_SRC-1:0][TAG_W-1:0]  src_tag_o,
   input  logic                           ren_valid_i,
   input  logic [ADDR_W-1:0]              ren_addr_i,
   input  logic [TAG_W-1:0]               ren_tag_i,
   input  logic                           res_valid_i,
   input  logic [TAG_W-1:0]               res_tag_i,
   input  logic [DATA_W-1:0]              res_data_i
);
   // Elaboration-time parameter checks
   if (NUM_REGS < 2 || (1 << ADDR_W) != NUM_REGS) begin : g_chk_regs
      $error("rrt_rename_table: NUM_REGS must be a power of two >= 2");
   end
   if (TAG_W < 1 || TAG_W > 16) begin : g_chk_tag
      $error("rrt_rename_table: TAG_W out of range");
   end
   if (NUM_SRC < 1 || NUM_SRC > 8) begin : g_chk_src
      $error("rrt_rename_table: NUM_SRC out of range");
   end
   if (DATA_W < 1) begin : g_chk_data
      $error("rrt_rename_table: DATA_W must be positive");
   end

   logic [NUM_REGS-1:0]             ren_hit;
   logic [NUM_REGS-1:0][TAG_W-1:0]  q_all;
   logic [NUM_REGS-1:0][DATA_W-1:0] v_all;

   rrt_ren_decode #(
      .NUM_REGS (NUM_REGS),
      .TAG_W    (TAG_W)
   ) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .ren_valid_i (ren_valid_i),
      .ren_addr_i  (ren_addr_i),
      .ren_tag_i   (ren_tag_i),
      .ren_hit_o   (ren_hit)
   );

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      rrt_entry #(
         .DATA_W    (DATA_W),
         .TAG_W     (TAG_W),
         .CLEAR_VAL (CLEAR_VAL)
      ) u_entry (
         .clk         (clk),
         .rst_n       (rst_n),
         .flush_i     (flush_i),
         .ren_hit_i   (ren_hit[r]),
         .ren_tag_i   (ren_tag_i),
         .res_valid_i (res_valid_i),
         .res_tag_i   (res_tag_i),
         .res_data_i  (res_data_i),
         .q_o         (q_all[r]),
         .v_o         (v_all[r])
      );
   end

   for (genvar p = 0; p < NUM_SRC; p++) begin : g_src
      rrt_read_port #(
         .NUM_REGS (NUM_REGS),
         .DATA_W   (DATA_W),
         .TAG_W    (TAG_W)
      ) u_port (
         .clk         (clk),
         .rst_n       (rst_n),
         .addr_i      (src_addr_i[p]),
         .q_all_i     (q_all),
         .v_all_i     (v_all),
         .res_valid_i (res_valid_i),
         .res_tag_i   (res_tag_i),
         .res_data_i  (res_data_i),
         .ready_o     (src_ready_o[p]),
         .value_o     (src_value_o[p]),
         .tag_o       (src_tag_o[p])
      );
   end

   // R10: ports naming one register give identical answers
   if (NUM_SRC > 1) begin : g_same_addr_chk
      p_ports_agree_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (src_addr_i[0] == src_addr_i[1]) |->
            (src_ready_o[0] == src_ready_o[1] && src_tag_o[0] == src_tag_o[1]));
   end
endmodule

// File: tb/rrt_rename_table_tb.sv
module rrt_rename_table_tb_top;
   localparam int NR = 16;
   localparam int DW = 32;
   localparam int TW = 4;
   localparam int NS = 2;
   localparam int AW = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic                   rst_n;
   logic                   flush_i;
   logic [NS-1:0][AW-1:0]  src_addr_i;
   logic [NS-1:0]          src_ready_o;
   logic [NS-1:0][DW-1:0]  src_value_o;
   logic [NS-1:0][TW-1:0]  src_tag_o;
   logic                   ren_valid_i;
   logic [AW-1:0]          ren_addr_i;
   logic [TW-1:0]          ren_tag_i;
   logic                   res_valid_i;
   logic [TW-1:0]          res_tag_i;
   logic [DW-1:0]          res_data_i;

   rrt_rename_table dut_i (
      .clk (clk), .rst_n (rst_n), .flush_i (flush_i),
      .src_addr_i (src_addr_i), .src_ready_o (src_ready_o),
      .src_value_o (src_value_o), .src_tag_o (src_tag_o),
      .ren_valid_i (ren_valid_i), .ren_addr_i (ren_addr_i), .ren_tag_i (ren_tag_i),
      .res_valid_i (res_valid_i), .res_tag_i (res_tag_i), .res_data_i (res_data_i)
   );

   logic [DW-1:0] mv [NR];
   logic [TW-1:0] mq [NR];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Expected answer of one port from the model (R2, R3, R8)
   task automatic check_src(input int p, input string req_in);
      logic [TW-1:0] q;
      string req;
      int a;
      a = int'(src_addr_i[p]);
      q = mq[a];
      if (q == '0) begin
         req = (req_in == "") ? "R2" : req_in;
         chk(src_ready_o[p] == 1'b1, req, "ready", DW'(src_ready_o[p]), 1);
         chk(src_value_o[p] == mv[a], req, "value", src_value_o[p], mv[a]);
      end else if (res_valid_i && res_tag_i == q) begin
         req = (req_in == "") ? "R8" : req_in;
         chk(src_ready_o[p] == 1'b1, req, "bypass ready", DW'(src_ready_o[p]), 1);
         chk(src_value_o[p] == res_data_i, req, "bypass value", src_value_o[p], res_data_i);
      end else begin
         req = (req_in == "") ? "R3" : req_in;
         chk(src_ready_o[p] == 1'b0, req, "ready", DW'(src_ready_o[p]), 0);
         chk(src_tag_o[p] == q, req, "tag", DW'(src_tag_o[p]), DW'(q));
      end
   endtask

   task automatic model_step();
      for (int r = 0; r < NR; r++) begin
         bit m;
         m = res_valid_i && res_tag_i != '0 && mq[r] == res_tag_i;
         if (flush_i) mq[r] = '0;
         else if (ren_valid_i && int'(ren_addr_i) == r) mq[r] = ren_tag_i;
         else if (m) mq[r] = '0;
         if (m) mv[r] = res_data_i;
      end
   endtask

   // Inputs are already driven after a negedge; check, then clock
   task automatic cycle(input string req);
      #2;
      for (int p = 0; p < NS; p++) check_src(p, req);
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic idle();
      flush_i = 0; ren_valid_i = 0; ren_addr_i = '0; ren_tag_i = '0;
      res_valid_i = 0; res_tag_i = '0; res_data_i = '0;
   endtask

   task automatic look(input int a0, input int a1);
      src_addr_i[0] = AW'(a0);
      src_addr_i[1] = AW'(a1);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      for (int r = 0; r < NR; r++) begin mv[r] = '0; mq[r] = '0; end
      rst_n = 0; idle(); look(0, 0);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1: reset state on every register
      for (int r = 0; r < NR; r += 2) begin look(r, r + 1); cycle("R1"); end

      // R4: rename seen next cycle, not in the same cycle
      look(3, 3); ren_valid_i = 1; ren_addr_i = 3; ren_tag_i = 5; cycle("R4");
      idle(); cycle("R4");

      // R6: other tag and tag 0 leave reg 3 untouched
      res_valid_i = 1; res_tag_i = 6; res_data_i = 32'hdead0006; cycle("R6");
      res_tag_i = 0; res_data_i = 32'hdead0000; cycle("R6");
      idle(); cycle("R6");

      // R8 then R5: bypass, then captured value
      res_valid_i = 1; res_tag_i = 5; res_data_i = 32'hcafe0005; cycle("R8");
      idle(); cycle("R5");

      // R7: rename and matching broadcast on reg 7 together
      look(7, 3); ren_valid_i = 1; ren_addr_i = 7; ren_tag_i = 9; cycle("R4");
      ren_tag_i = 10; res_valid_i = 1; res_tag_i = 9; res_data_i = 32'h7777_0009;
      cycle("R7");
      idle(); cycle("R7");
      // old tag 9 broadcast again must not hit (R6), then flush exposes value (R9/R7)
      res_valid_i = 1; res_tag_i = 9; res_data_i = 32'h1111_1111; cycle("R6");
      idle(); flush_i = 1; cycle("R9");
      idle(); cycle("R7");

      // R9: flush discards a same-cycle rename
      look(2, 2); ren_valid_i = 1; ren_addr_i = 2; ren_tag_i = 3; flush_i = 1; cycle("R9");
      idle(); cycle("R9");

      // Random phase: both ports, same-address cases included (R10)
      for (int i = 0; i < 4000; i++) begin
         int a0, a1, pick;
         idle();
         a0 = $urandom_range(NR - 1);
         a1 = ($urandom_range(3) == 0) ? a0 : $urandom_range(NR - 1);
         look(a0, a1);
         if ($urandom_range(2) != 0) begin
            ren_valid_i = 1;
            ren_addr_i = AW'($urandom_range(NR - 1));
            ren_tag_i = TW'($urandom_range(15, 1));
         end
         if ($urandom_range(1) != 0) begin
            res_valid_i = 1;
            res_data_i = $urandom;
            pick = $urandom_range(NR - 1);
            res_tag_i = ($urandom_range(4) != 0) ? mq[pick] : TW'($urandom_range(15));
         end
         if ($urandom_range(150) == 0) flush_i = 1;
         cycle((a0 == a1) ? "" : "");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule